// File: doc/BRIEF.md
# Cache Line Allocator with Programmable Set Decoder

This block is the tag and placement side of a first-level cache that keeps direct-mapped access time while spreading busy sets over several physical lines. Set selection is split in two. A fixed decoder picks a group of lines from one slice of the address. A small content-addressable decoder then compares a second address slice, the key, against a rewritable key held for every line in that group. A hit therefore still resolves in one lookup cycle, but any line of the group can hold any key, which gives placement freedom close to that of a set-associative cache.

A lookup whose key matches no entry is known to miss before the tag array is touched, so the tag read is suppressed. On a miss the block picks a victim line inside the group, by least-recently-used ages or by a free-running pseudo-random register (chosen by a parameter). It raises a refill request with the line address and blocks the lookup port. When the next level acknowledges, the victim's tag, valid bit and decoder key are written in a single cycle. Line data and write-back are handled elsewhere; the block reports the physical line index that the data array should use.

Top module: `pdec_cache`

## Requirements
- R1: After reset the lookup port is ready, no refill is requested, no response is valid, and no line or decoder entry is valid, so every first lookup misses.
- R2: A 32-bit byte address is split as offset [4:0], group [10:5], key [16:11] and tag [31:17]. The reported line index is group*8 + way, with the way in the 3 low bits.
- R3: When no valid decoder entry of the addressed group holds the key, the lookup misses and the tag-read indicator `resp_arr_rd_o` is 0.
- R4: When a decoder entry matches and its line is valid with an equal tag, the response one cycle after acceptance shows hit=1, tag read=1 and that line's index.
- R5: When a decoder entry matches but the tag differs, the lookup misses with tag read=1, and the matched line is the victim.
- R6: On a miss `refill_req_o` is 1 with `refill_addr_o` equal to address bits [31:5]. The port stays not-ready until the cycle after `refill_ack_i` is seen, and refill_req falls in that same cycle.
- R7: The acknowledged fill writes tag, key and valid bits of the victim line in one cycle, so the same address then hits on that line.
- R8: With the LRU policy each way holds a 3-bit age. Ages reset to the way number, a hit or fill sets the touched way to 0 and increments every younger way, and the victim is the way of age 7.
- R9: With the random policy an 8-bit LFSR (feedback bit7^bit5^bit4^bit3 shifted into bit 0, seed 1) advances every cycle. Its low 3 bits give the victim way, which always lies inside the addressed group.
- R10: The offset bits have no effect: addresses that differ only in bits [4:0] resolve to the same line and hit result.
- R11: At most one decoder entry in a group matches any key, so keys stay unique within a group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Lookup request |
| req_addr_i | input | 32 | Lookup byte address |
| req_ready_o | output | 1 | Lookup port can accept |
| resp_valid_o | output | 1 | Lookup result valid (one cycle after acceptance) |
| resp_hit_o | output | 1 | Lookup hit |
| resp_line_o | output | 9 | Physical line index: hit line or victim |
| resp_arr_rd_o | output | 1 | Tag array was read for this lookup |
| refill_req_o | output | 1 | Refill request to next level |
| refill_addr_o | output | 27 | Line address of the refill |
| refill_ack_i | input | 1 | Refill data delivered |

## Verification
The bench builds two copies with the default geometry of 64 groups of 8 ways, 6-bit keys and 15-bit tags. One copy uses the LRU policy and is followed lookup by lookup by a behavioural model, which predicts hits, victims, tag-read suppression and the refill handshake. The small group and key range bring key collisions, tag mismatches on matched keys and full LRU eviction cycles within a few hundred lookups. The second copy uses the random policy and is checked for in-group victims and hits again at once after a fill.

// File: rtl/pdec_cache_pkg.sv
package pdec_cache_pkg;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_OFF_W  = 5;
  localparam int unsigned DEF_FIX_W  = 6;
  localparam int unsigned DEF_KEY_W  = 6;
  localparam int unsigned DEF_WAYS   = 8;

  typedef enum logic [0:0] {
    ST_LOOKUP = 1'b0,
    ST_REFILL = 1'b1
  } pdc_state_e;
endpackage

// File: rtl/pdec_line_store.sv
module pdec_line_store #(
  parameter int unsigned NGRP  = 64,
  parameter int unsigned WAYS  = 8,
  parameter int unsigned KEY_W = 6,
  parameter int unsigned TAG_W = 15,
  localparam int unsigned GRP_W = $clog2(NGRP),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [GRP_W-1:0]            rd_grp_i,
  output logic [WAYS-1:0]             rd_kv_o,
  output logic [WAYS-1:0]             rd_lv_o,
  output logic [WAYS-1:0][KEY_W-1:0]  rd_key_o,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag_o,
  input  logic                        wr_i,
  input  logic [GRP_W-1:0]            wr_grp_i,
  input  logic [WAY_W-1:0]            wr_way_i,
  input  logic [KEY_W-1:0]            wr_key_i,
  input  logic [TAG_W-1:0]            wr_tag_i
);
  logic [WAYS-1:0]            kv_q  [NGRP];
  logic [WAYS-1:0]            lv_q  [NGRP];
  logic [WAYS-1:0][KEY_W-1:0] key_q [NGRP];
  logic [WAYS-1:0][TAG_W-1:0] tag_q [NGRP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < NGRP; g++) begin
        kv_q[g] <= '0;
        lv_q[g] <= '0;
      end
    end else if (wr_i) begin
      kv_q[wr_grp_i][wr_way_i] <= 1'b1;
      lv_q[wr_grp_i][wr_way_i] <= 1'b1;
    end
  end

  // payload arrays carry no reset; valid bits gate them
  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      key_q[wr_grp_i][wr_way_i] <= wr_key_i;
      tag_q[wr_grp_i][wr_way_i] <= wr_tag_i;
    end
  end

  assign rd_kv_o  = kv_q[rd_grp_i];
  assign rd_lv_o  = lv_q[rd_grp_i];
  assign rd_key_o = key_q[rd_grp_i];
  assign rd_tag_o = tag_q[rd_grp_i];

  assert_fill_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (kv_q[$past(wr_grp_i)][$past(wr_way_i)] && lv_q[$past(wr_grp_i)][$past(wr_way_i)]));
endmodule

// File: rtl/pdec_group_match.sv
module pdec_group_match #(
  parameter int unsigned WAYS  = 8,
  parameter int unsigned KEY_W = 6,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            key_vld_i,
  input  logic [WAYS-1:0][KEY_W-1:0] keys_i,
  input  logic [KEY_W-1:0]           key_i,
  output logic [WAYS-1:0]            match_o,
  output logic                       any_o,
  output logic [WAY_W-1:0]           way_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_o[w] = key_vld_i[w] && (keys_i[w] == key_i);
  end

  assign any_o = |match_o;

  always_comb begin
    way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match_o[w]) way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/pdec_victim_sel.sv
module pdec_victim_sel #(
  parameter int unsigned NGRP    = 64,
  parameter int unsigned WAYS    = 8,
  parameter bit          USE_LRU = 1'b1,
  localparam int unsigned GRP_W  = $clog2(NGRP),
  localparam int unsigned WAY_W  = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GRP_W-1:0] grp_i,
  input  logic             touch_i,
  input  logic [GRP_W-1:0] touch_grp_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAY_W-1:0] victim_o
);
  if (USE_LRU) begin : g_lru
    logic [WAY_W-1:0] age_q [NGRP][WAYS];
    logic [WAYS-1:0]  old_vec;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int g = 0; g < NGRP; g++)
          for (int w = 0; w < WAYS; w++)
            age_q[g][w] <= WAY_W'(w);
      end else if (touch_i) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touch_way_i)
            age_q[touch_grp_i][w] <= '0;
          else if (age_q[touch_grp_i][w] < age_q[touch_grp_i][touch_way_i])
            age_q[touch_grp_i][w] <= age_q[touch_grp_i][w] + 1'b1;
        end
      end
    end

    always_comb begin
      victim_o = '0;
      for (int w = 0; w < WAYS; w++) begin
        old_vec[w] = (age_q[grp_i][w] == WAY_W'(WAYS-1));
        if (old_vec[w]) victim_o = WAY_W'(w);
      end
    end

    // ages within a group stay a permutation: exactly one oldest way
    assert_single_oldest_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(old_vec) == 1);
  end else begin : g_rnd
    localparam int unsigned LFSR_W = 8;
    logic [LFSR_W-1:0] lfsr_q;
    logic              unused_touch;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lfsr_q <= LFSR_W'(1);
      else         lfsr_q <= {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
    end

    assign victim_o     = lfsr_q[WAY_W-1:0];
    assign unused_touch = ^{grp_i, touch_i, touch_grp_i, touch_way_i, lfsr_q[LFSR_W-1:WAY_W]};

    assert_lfsr_live_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lfsr_q != '0);
  end
endmodule

// File: rtl/pdec_cache.sv
module pdec_cache
  import pdec_cache_pkg::*;
#(
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned OFF_W   = DEF_OFF_W,
  parameter int unsigned FIX_W   = DEF_FIX_W,
  parameter int unsigned KEY_W   = DEF_KEY_W,
  parameter int unsigned WAYS    = DEF_WAYS,
  parameter bit          USE_LRU = 1'b1,
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned NGRP   = 1 << FIX_W,
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - FIX_W - KEY_W,
  localparam int unsigned LINE_W = FIX_W + WAY_W,
  localparam int unsigned LA_W   = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [LINE_W-1:0] resp_line_o,
  output logic              resp_arr_rd_o,
  output logic              refill_req_o,
  output logic [LA_W-1:0]   refill_addr_o,
  input  logic              refill_ack_i
);
  pdc_state_e state_q;

  logic [FIX_W-1:0] lk_grp;
  logic [KEY_W-1:0] lk_key;
  logic [TAG_W-1:0] lk_tag;
  logic             unused_off;

  assign lk_grp     = req_addr_i[OFF_W +: FIX_W];
  assign lk_key     = req_addr_i[OFF_W+FIX_W +: KEY_W];
  assign lk_tag     = req_addr_i[ADDR_W-1 -: TAG_W];
  assign unused_off = ^req_addr_i[OFF_W-1:0];

  logic [WAYS-1:0]            rd_kv, rd_lv, match;
  logic [WAYS-1:0][KEY_W-1:0] rd_key;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic                       key_hit;
  logic [WAY_W-1:0]           match_way, pol_way, vict_way;

  logic [FIX_W-1:0] fill_grp_q;
  logic [WAY_W-1:0] fill_way_q;
  logic [KEY_W-1:0] fill_key_q;
  logic [TAG_W-1:0] fill_tag_q;

  logic accept, lk_hit, fill_wr, touch;
  logic [FIX_W-1:0] touch_grp;
  logic [WAY_W-1:0] touch_way;

  assign accept  = req_valid_i && (state_q == ST_LOOKUP);
  assign fill_wr = (state_q == ST_REFILL) && refill_ack_i;

  pdec_line_store #(
    .NGRP(NGRP), .WAYS(WAYS), .KEY_W(KEY_W), .TAG_W(TAG_W)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_grp_i (lk_grp),
    .rd_kv_o  (rd_kv),
    .rd_lv_o  (rd_lv),
    .rd_key_o (rd_key),
    .rd_tag_o (rd_tag),
    .wr_i     (fill_wr),
    .wr_grp_i (fill_grp_q),
    .wr_way_i (fill_way_q),
    .wr_key_i (fill_key_q),
    .wr_tag_i (fill_tag_q)
  );

  pdec_group_match #(.WAYS(WAYS), .KEY_W(KEY_W)) u_match (
    .key_vld_i (rd_kv),
    .keys_i    (rd_key),
    .key_i     (lk_key),
    .match_o   (match),
    .any_o     (key_hit),
    .way_o     (match_way)
  );

  // tag array is only consulted behind a decoder match
  assign lk_hit   = key_hit && rd_lv[match_way] && (rd_tag[match_way] == lk_tag);
  assign vict_way = key_hit ? match_way : pol_way;

  assign touch     = (accept && lk_hit) || fill_wr;
  assign touch_grp = fill_wr ? fill_grp_q : lk_grp;
  assign touch_way = fill_wr ? fill_way_q : match_way;

  pdec_victim_sel #(.NGRP(NGRP), .WAYS(WAYS), .USE_LRU(USE_LRU)) u_victim (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .grp_i       (lk_grp),
    .touch_i     (touch),
    .touch_grp_i (touch_grp),
    .touch_way_i (touch_way),
    .victim_o    (pol_way)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_LOOKUP;
      resp_valid_o  <= 1'b0;
      resp_hit_o    <= 1'b0;
      resp_line_o   <= '0;
      resp_arr_rd_o <= 1'b0;
      refill_addr_o <= '0;
      fill_grp_q    <= '0;
      fill_way_q    <= '0;
      fill_key_q    <= '0;
      fill_tag_q    <= '0;
    end else begin
      resp_valid_o <= accept;
      if (accept) begin
        resp_hit_o    <= lk_hit;
        resp_arr_rd_o <= key_hit;
        resp_line_o   <= {lk_grp, lk_hit ? match_way : vict_way};
        if (!lk_hit) begin
          state_q       <= ST_REFILL;
          refill_addr_o <= req_addr_i[ADDR_W-1:OFF_W];
          fill_grp_q    <= lk_grp;
          fill_way_q    <= vict_way;
          fill_key_q    <= lk_key;
          fill_tag_q    <= lk_tag;
        end
      end else if (fill_wr) begin
        state_q <= ST_LOOKUP;
      end
    end
  end

  assign req_ready_o  = (state_q == ST_LOOKUP);
  assign refill_req_o = (state_q == ST_REFILL);

  assert_unique_key_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> $onehot0(match));
  assert_resp_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> resp_valid_o);
  assert_hit_reads_tag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_hit_o) |-> resp_arr_rd_o);
  assert_miss_refills_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_hit_o) |-> (refill_req_o && !req_ready_o));
  assert_refill_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_req_o && !refill_ack_i) |=> (refill_req_o && $stable(refill_addr_o)));
  assert_line_group_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> resp_line_o[LINE_W-1:WAY_W] == $past(lk_grp));
endmodule

// File: tb/test_pdec_cache.sv
`timescale 1ns/1ps
module test_pdec_cache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        valid_a = 0, ack_a = 0, valid_b = 0, ack_b = 0;
  logic [31:0] addr_a = '0, addr_b = '0;
  logic        rdy_a, rv_a, hit_a, ard_a, rq_a;
  logic        rdy_b, rv_b, hit_b, ard_b, rq_b;
  logic [8:0]  line_a, line_b;
  logic [26:0] radr_a, radr_b;

  pdec_cache #(.USE_LRU(1'b1)) i_pdec_cache (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid_a), .req_addr_i(addr_a),
    .req_ready_o(rdy_a), .resp_valid_o(rv_a), .resp_hit_o(hit_a), .resp_line_o(line_a),
    .resp_arr_rd_o(ard_a), .refill_req_o(rq_a), .refill_addr_o(radr_a), .refill_ack_i(ack_a));

  pdec_cache #(.USE_LRU(1'b0)) i_pdec_cache_rnd (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid_b), .req_addr_i(addr_b),
    .req_ready_o(rdy_b), .resp_valid_o(rv_b), .resp_hit_o(hit_b), .resp_line_o(line_b),
    .resp_arr_rd_o(ard_b), .refill_req_o(rq_b), .refill_addr_o(radr_b), .refill_ack_i(ack_b));

  int n_cmp = 0, n_bad = 0;

  task automatic chk(string req, longint act, longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model of the LRU copy
  bit mkv [64][8];
  bit mlv [64][8];
  int mkey[64][8];
  int mtag[64][8];
  int mage[64][8];

  task automatic model_reset();
    for (int g = 0; g < 64; g++)
      for (int w = 0; w < 8; w++) begin
        mkv[g][w] = 0; mlv[g][w] = 0; mage[g][w] = w;
      end
  endtask

  task automatic model_touch(int g, int w);
    int a = mage[g][w];
    for (int i = 0; i < 8; i++)
      if (i == w) mage[g][i] = 0;
      else if (mage[g][i] < a) mage[g][i]++;
  endtask

  function automatic logic [31:0] mk_addr(int tag, int key, int grp, int off);
    return {tag[14:0], key[5:0], grp[5:0], off[4:0]};
  endfunction

  task automatic lookup_a(logic [31:0] a, int ack_dly, string tagn);
    int g = a[10:5], k = a[16:11], t = a[31:17];
    int mw = -1, vw = 0;
    bit ehit;
    for (int w = 0; w < 8; w++) if (mkv[g][w] && mkey[g][w] == k) mw = w;
    ehit = (mw >= 0) && mlv[g][mw] && (mtag[g][mw] == t);
    if (mw >= 0) vw = mw;
    else for (int w = 0; w < 8; w++) if (mage[g][w] == 7) vw = w;
    @(negedge clk);
    chk({tagn, " R6 ready before request"}, rdy_a, 1);
    valid_a = 1; addr_a = a;
    @(negedge clk);
    valid_a = 0;
    chk({tagn, " R4 resp_valid"}, rv_a, 1);
    chk({tagn, " R4/R3/R5 hit"}, hit_a, ehit);
    chk({tagn, " R3/R5 tag read"}, ard_a, mw >= 0);
    chk({tagn, " R2/R8 line"}, line_a, g * 8 + vw);
    if (ehit) begin
      chk({tagn, " R6 no refill on hit"}, rq_a, 0);
      model_touch(g, vw);
    end else begin
      chk({tagn, " R6 refill_req"}, rq_a, 1);
      chk({tagn, " R6 refill_addr"}, radr_a, a[31:5]);
      chk({tagn, " R6 blocked"}, rdy_a, 0);
      for (int i = 0; i < ack_dly; i++) begin
        @(negedge clk);
        chk({tagn, " R6 still waiting"}, {rq_a, rdy_a, rv_a}, 3'b100);
      end
      ack_a = 1;
      @(negedge clk);
      ack_a = 0;
      chk({tagn, " R6 released after ack"}, {rq_a, rdy_a, rv_a}, 3'b010);
      mkv[g][vw] = 1; mlv[g][vw] = 1; mkey[g][vw] = k; mtag[g][vw] = t;
      model_touch(g, vw);
    end
  endtask

  task automatic lookup_b(logic [31:0] a, output bit h, output int ln);
    @(negedge clk);
    valid_b = 1; addr_b = a;
    @(negedge clk);
    valid_b = 0;
    h = hit_b; ln = line_b;
    chk("R9 resp_valid random copy", rv_b, 1);
    chk("R9 victim inside group", line_b[8:3], a[10:5]);
    if (!hit_b) begin
      chk("R6 refill_addr random copy", radr_b, a[31:5]);
      ack_b = 1;
      @(negedge clk);
      ack_b = 0;
      chk("R6 random copy released", rdy_b, 1);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    bit h; int ln, ln2;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset ready", rdy_a, 1);
    chk("R1 reset no refill", rq_a, 0);
    chk("R1 reset no response", rv_a, 0);

    // R1/R3/R8: first access misses without tag read, way 7 is oldest
    lookup_a(mk_addr(5, 3, 9, 0), 0, "first");
    chk("R8 first victim way 7", line_a, 9 * 8 + 7);
    lookup_a(mk_addr(5, 3, 9, 4), 1, "R7 refill then hit");
    lookup_a(mk_addr(5, 3, 9, 31), 0, "R10 offset ignored");
    chk("R10 same line", line_a, 9 * 8 + 7);
    // R3 different key, same group
    lookup_a(mk_addr(5, 4, 9, 0), 2, "R3 new key");
    // R5 matching key, different tag: reuse line, keep keys unique (R11)
    lookup_a(mk_addr(6, 3, 9, 0), 0, "R5 tag mismatch");
    chk("R5 victim is matched line", line_a, 9 * 8 + 7);
    lookup_a(mk_addr(5, 3, 9, 0), 0, "R11 old tag gone");
    // R8 fill a whole group and force LRU eviction
    for (int k = 10; k < 20; k++) lookup_a(mk_addr(1, k, 40, 0), k % 3, "R8 fill group");
    lookup_a(mk_addr(1, 12, 40, 0), 0, "R8 touch");
    lookup_a(mk_addr(1, 30, 40, 0), 0, "R8 evict");
    // R2 distinct groups
    lookup_a(mk_addr(7, 1, 0, 0), 0, "R2 group 0");
    lookup_a(mk_addr(7, 1, 63, 0), 0, "R2 group 63");
    lookup_a(mk_addr(7, 1, 63, 2), 0, "R2 group 63 hit");
    // mixed stream
    for (int i = 0; i < 300; i++) begin
      int g = ($urandom % 2) ? 21 : 50;
      lookup_a(mk_addr($urandom % 3, $urandom % 10, g, $urandom % 32), $urandom % 3, "stream");
    end

    // random-policy copy (R9)
    for (int k = 0; k < 12; k++) begin
      lookup_b(mk_addr(2, k, 17, 0), h, ln);
      chk("R9 first access misses", h, 0);
      lookup_b(mk_addr(2, k, 17, 8), h, ln2);
      chk("R7 random copy hits after fill", h, 1);
      chk("R7 random copy same line", ln2, ln);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule